// File: doc/BRIEF.md
# GPIO Pad Controller with Shared Interrupt Lines

This block controls a parameterised set of general-purpose pads through a register port. Every pad owns two 32-bit control words. The first word holds the pad's direction mode, its function enable, a termination select, the output value, the read-only sampled input and the number of the shared interrupt line the pad feeds. The second word holds the trigger code and an input inversion bit. Pads are laid out in address windows of fifteen. Each window is 0x400 bytes, and the pad words sit 8 bytes apart inside it.

Each pad input passes through a two-flop synchronizer. While receive is enabled, the pad watches its synchronized input (inverted if selected) for a falling edge, a rising edge, either edge or a high level. A qualifying event sets one of sixteen status bits, chosen by the pad's line field. Software clears the status bits by writing ones and opens them onto the single interrupt output through a mask register. Edge lines are cleared before service. Level lines are cleared after the source has gone quiet, because hardware sets them again for as long as the input stays active.

The register port takes one request per cycle and applies no back-pressure. A write takes effect at the clock edge that samples it. A read returns its data with `rsp_valid` one cycle later.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, all pad control words, the status register and the mask register read zero, `irq_out` is low and no pad drives (`pad_oe` low).
- R2: Pad n's first word is at 0x4400 + (n/15)*0x400 + (n%15)*8 and its second word is 4 bytes above. In the first word only bit 1 (output value), bits 10:8 (mode), bit 15 (enable), bit 23 (pull-up) and bits 31:28 (line) are stored, and bit 0 is read-only. In the second word only bits 2:0 (trigger) and bit 6 (invert) are stored. All other bits read zero.
- R3: Reads of any other offset, including window slots 15 and above and pads past the last one, return zero, and writes to them change no register.
- R4: `pad_oe` of a pad is high exactly when its enable bit is set and its mode is 0 (receive and transmit) or 1 (transmit only). `pad_out` follows the output value bit.
- R5: Bit 0 of the first word shows the synchronized pad input while the pad is enabled with mode 0 or 2 (receive only), and reads zero otherwise.
- R6: Trigger codes 1, 2 and 3 (falling, rising, either edge) set the status bit selected by the line field once per qualifying edge of the synchronized input.
- R7: Trigger code 4 (level) keeps setting the selected status bit on every cycle the input is active, so a clear while the input is active does not stick.
- R8: Bit 6 of the second word inverts the input before detection, so an active-low level source uses level trigger with inversion set.
- R9: Trigger code 0, a disabled pad, or a mode without receive (1 or 3) sets no status bit.
- R10: The 16-bit status register at 0x300 clears each bit written as one and keeps each bit written as zero.
- R11: When a hardware set and a software clear reach the same status bit in the same cycle, the bit ends up set.
- R12: The mask register at 0x380 reads back as written. `irq_out` is high in the cycle after any status bit and its mask bit are both one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | NUM_PADS | Asynchronous pad inputs |
| pad_out | output | NUM_PADS | Pad output values |
| pad_oe | output | NUM_PADS | Pad output enables |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
The collision that matters is a detected pad edge setting a status bit in the same cycle that a software write-one-to-clear reaches that bit. The bench provokes it by changing a pad input at a known negative edge. It counts the two synchronizer stages, then presents the clearing write on the exact edge where the status bit is set, and it expects the bit to read back as one. A second clear with no input activity must then leave the bit at zero. This shows that the first clear was not lost to a broken clear path.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int LINES        = 16;
  localparam int LINE_W       = 4;
  localparam int STAT_OFS     = 'h300;
  localparam int MASK_OFS     = 'h380;
  localparam int PAD_BASE     = 'h4400;
  localparam int PADS_PER_WIN = 15;
  localparam int WIN_STRIDE   = 'h400;
  localparam int SLOT_STRIDE  = 8;
  localparam int WORD1_OFS    = 4;

  // direction mode encodings (first word bits 10:8)
  localparam logic [2:0] MODE_RXTX = 3'd0;
  localparam logic [2:0] MODE_TX   = 3'd1;
  localparam logic [2:0] MODE_RX   = 3'd2;

  typedef enum logic [2:0] {
    TRIG_NONE  = 3'd0,
    TRIG_FALL  = 3'd1,
    TRIG_RISE  = 3'd2,
    TRIG_BOTH  = 3'd3,
    TRIG_LEVEL = 3'd4
  } trig_e;

  typedef struct packed {
    logic [LINE_W-1:0] line;
    logic              pull;
    logic              en;
    logic [2:0]        mode;
    logic              tx;
  } ctl0_t;

  typedef struct packed {
    logic       inv;
    logic [2:0] trig;
  } ctl1_t;

  function automatic int pad_addr(input int n, input int word);
    return PAD_BASE + (n / PADS_PER_WIN) * WIN_STRIDE
         + (n % PADS_PER_WIN) * SLOT_STRIDE + word * WORD1_OFS;
  endfunction
endpackage

// File: rtl/gpio_pad_slice.sv
module gpio_pad_slice
  import gpio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr0,
  input  logic             wr1,
  input  logic [31:0]      wdata,
  input  logic             pad_in,
  output logic [31:0]      word0,
  output logic [31:0]      word1,
  output logic             pad_out,
  output logic             pad_oe,
  output logic [LINES-1:0] line_set
);
  ctl0_t      c0_q;
  ctl1_t      c1_q;
  logic [1:0] sync_q;
  logic       prev_q;
  logic       din;
  logic       rx_on;
  logic       tx_on;
  logic       hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c0_q <= '0;
      c1_q <= '0;
    end else begin
      if (wr0) c0_q <= '{line: wdata[31:28], pull: wdata[23], en: wdata[15],
                         mode: wdata[10:8], tx: wdata[1]};
      if (wr1) c1_q <= '{inv: wdata[6], trig: wdata[2:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pad_in};
      prev_q <= din;
    end
  end

  assign din   = sync_q[1] ^ c1_q.inv;
  assign rx_on = c0_q.en && (c0_q.mode == MODE_RXTX || c0_q.mode == MODE_RX);
  assign tx_on = c0_q.en && (c0_q.mode == MODE_RXTX || c0_q.mode == MODE_TX);

  always_comb begin
    case (c1_q.trig)
      TRIG_FALL:  hit = ~din & prev_q;
      TRIG_RISE:  hit = din & ~prev_q;
      TRIG_BOTH:  hit = din ^ prev_q;
      TRIG_LEVEL: hit = din;
      default:    hit = 1'b0;
    endcase
  end

  assign line_set = (rx_on && hit) ? (LINES'(1) << c0_q.line) : '0;
  assign pad_oe   = tx_on;
  assign pad_out  = c0_q.tx;

  assign word0 = {c0_q.line, 4'b0, c0_q.pull, 7'b0, c0_q.en, 4'b0, c0_q.mode,
                  6'b0, c0_q.tx, rx_on & sync_q[1]};
  assign word1 = {25'b0, c1_q.inv, 3'b0, c1_q.trig};
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
  import gpio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_set,
  input  logic             clr_we,
  input  logic [LINES-1:0] clr_bits,
  input  logic             mask_we,
  input  logic [LINES-1:0] mask_wdata,
  output logic [LINES-1:0] status,
  output logic [LINES-1:0] mask,
  output logic             irq_out
);
  logic [LINES-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status  <= '0;
      mask    <= '0;
      irq_out <= 1'b0;
    end else begin
      status  <= (status & ~clr_eff) | line_set;  // hardware set has priority
      if (mask_we) mask <= mask_wdata;
      irq_out <= |(status & mask);
    end
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PADS = 20,
  parameter int ADDR_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  output logic [31:0]         rsp_rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic                irq_out
);
  logic [NUM_PADS-1:0] sel0;
  logic [NUM_PADS-1:0] sel1;
  logic [31:0]         w0_arr  [NUM_PADS];
  logic [31:0]         w1_arr  [NUM_PADS];
  logic [LINES-1:0]    set_arr [NUM_PADS];
  logic [LINES-1:0]    line_set;
  logic [LINES-1:0]    status_vec;
  logic [LINES-1:0]    mask_vec;
  logic                sel_stat;
  logic                sel_mask;
  logic                wr_status;
  logic [31:0]         rd_mux;

  assign sel_stat  = (req_addr == ADDR_W'(STAT_OFS));
  assign sel_mask  = (req_addr == ADDR_W'(MASK_OFS));
  assign wr_status = req_valid && req_write && sel_stat;

  for (genvar n = 0; n < NUM_PADS; n++) begin : g_pad
    localparam int A0 = pad_addr(n, 0);
    localparam int A1 = pad_addr(n, 1);
    assign sel0[n] = (req_addr == ADDR_W'(A0));
    assign sel1[n] = (req_addr == ADDR_W'(A1));

    gpio_pad_slice u_pad (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr0      (req_valid && req_write && sel0[n]),
      .wr1      (req_valid && req_write && sel1[n]),
      .wdata    (req_wdata),
      .pad_in   (pad_in[n]),
      .word0    (w0_arr[n]),
      .word1    (w1_arr[n]),
      .pad_out  (pad_out[n]),
      .pad_oe   (pad_oe[n]),
      .line_set (set_arr[n])
    );
  end

  always_comb begin
    line_set = '0;
    for (int n = 0; n < NUM_PADS; n++) line_set = line_set | set_arr[n];
  end

  gpio_irq_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_set   (line_set),
    .clr_we     (wr_status),
    .clr_bits   (req_wdata[LINES-1:0]),
    .mask_we    (req_valid && req_write && sel_mask),
    .mask_wdata (req_wdata[LINES-1:0]),
    .status     (status_vec),
    .mask       (mask_vec),
    .irq_out    (irq_out)
  );

  always_comb begin
    rd_mux = '0;
    if (sel_stat) rd_mux = {{(32-LINES){1'b0}}, status_vec};
    if (sel_mask) rd_mux = {{(32-LINES){1'b0}}, mask_vec};
    for (int n = 0; n < NUM_PADS; n++) begin
      if (sel0[n]) rd_mux = w0_arr[n];
      if (sel1[n]) rd_mux = w1_arr[n];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [15:0] wdata_lo,
  input logic        status_wr,
  input logic [15:0] status,
  input logic [15:0] mask,
  input logic [15:0] line_set,
  input logic        irq_out,
  input logic        rsp_valid
);
  // R1: reset empties status and quiets the interrupt
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (status == '0 && mask == '0 && !irq_out));

  // R2: read data follows each read request by one cycle
  p_rsp_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid && !req_write));

  // R10: a one written to status clears that bit when no set hits it
  p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && line_set == '0) |=> ((status & $past(wdata_lo)) == '0));

  // R10: a status bit rises only through a hardware set
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(line_set)) == '0));

  // R11: a set always lands, even against a clear
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (line_set != '0) |=> ((status & $past(line_set)) == $past(line_set)));

  // R12: combined output follows masked status one cycle later
  p_irq_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(|(status & mask)));
endmodule

bind gpio_irq_router gpio_irq_router_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .wdata_lo  (req_wdata[15:0]),
  .status_wr (wr_status),
  .status    (status_vec),
  .mask      (mask_vec),
  .line_set  (line_set),
  .irq_out   (irq_out),
  .rsp_valid (rsp_valid)
);

// File: tb/gpio_irq_router_tb.sv
module gpio_irq_router_tb;
  localparam int NP = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [15:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;
  logic          irq_out;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  gpio_irq_router #(.NUM_PADS(NP), .ADDR_W(16)) u_dut (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_rdata, .pad_in, .pad_out, .pad_oe, .irq_out
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic reg_read(input logic [15:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (rsp_valid) begin
      if (sb_q.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R2 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(rsp_rdata, e.exp, e.tag);
      end
    end
  end

  localparam logic [15:0] ST = 16'h0300;
  localparam logic [15:0] MK = 16'h0380;
  localparam logic [15:0] P0W0 = 16'h4400, P0W1 = 16'h4404;
  localparam logic [15:0] P14W0 = 16'h4470;
  localparam logic [15:0] P16W0 = 16'h4808, P16W1 = 16'h480C;

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk({31'b0, irq_out}, 0, "R1 irq_out");
    chk({12'b0, pad_oe}, 0, "R1 pad_oe");
    reg_read(ST, 0, "R1 status");
    reg_read(MK, 0, "R1 mask");
    reg_read(P16W1, 0, "R1 pad16 word1");

    // R2 field storage and address map (pad16 = window 1, slot 1)
    reg_write(P16W0, 32'hFFFF_FFFF);
    reg_read(P16W0, 32'hF080_8702, "R2 pad16 word0");
    reg_write(P16W1, 32'hFFFF_FFFF);
    reg_read(P16W1, 32'h0000_0047, "R2 pad16 word1");
    reg_write(P16W0, 0);
    reg_write(P16W1, 0);

    // R3 unmapped offsets
    reg_write(16'h4478, 32'hFFFF_FFFF);
    reg_read(16'h4478, 0, "R3 slot15 read");
    reg_read(P14W0, 0, "R3 pad14 untouched");
    reg_write(16'h4828, 32'hFFFF_FFFF);
    reg_read(16'h4828, 0, "R3 beyond last pad");
    reg_write(16'h1234, 32'hFFFF_FFFF);
    reg_read(16'h1234, 0, "R3 random offset");
    reg_read(ST, 0, "R3 status untouched");

    // R4 output enable by mode
    reg_write(P0W0, 32'h0000_8002);
    chk({31'b0, pad_oe[0]}, 1, "R4 oe mode0");
    chk({31'b0, pad_out[0]}, 1, "R4 pad_out");
    reg_write(P0W0, 32'h0000_8102);
    chk({31'b0, pad_oe[0]}, 1, "R4 oe mode1");
    reg_write(P0W0, 32'h0000_8200);
    chk({31'b0, pad_oe[0]}, 0, "R4 oe mode2");
    reg_write(P0W0, 32'h0000_0002);
    chk({31'b0, pad_oe[0]}, 0, "R4 oe disabled");

    // R5 sampled input
    reg_write(P0W0, 32'h0000_8200);
    pad_in[0] = 1'b1;
    tick(4);
    reg_read(P0W0, 32'h0000_8201, "R5 rx visible");
    reg_write(P0W0, 32'h0000_8100);
    reg_read(P0W0, 32'h0000_8100, "R5 rx hidden tx-only");
    pad_in[0] = 1'b0;
    tick(4);

    // R6 edges, pad0 on line 3
    reg_write(P0W0, 32'h3000_8200);
    reg_write(P0W1, 32'h2);
    reg_write(ST, 32'hFFFF);
    pad_in[0] = 1'b1; tick(5);
    reg_read(ST, 32'h0008, "R6 rising edge");
    reg_write(ST, 32'hFFFF); tick(4);
    reg_read(ST, 0, "R6 rising once");
    pad_in[0] = 1'b0; tick(5);
    reg_read(ST, 0, "R6 falling ignored by rising");
    reg_write(P0W1, 32'h1);
    pad_in[0] = 1'b1; tick(5);
    reg_read(ST, 0, "R6 rising ignored by falling");
    pad_in[0] = 1'b0; tick(5);
    reg_read(ST, 32'h0008, "R6 falling edge");
    reg_write(P0W1, 32'h3);
    reg_write(ST, 32'hFFFF);
    pad_in[0] = 1'b1; tick(5);
    reg_read(ST, 32'h0008, "R6 both rising");
    reg_write(ST, 32'hFFFF);
    pad_in[0] = 1'b0; tick(5);
    reg_read(ST, 32'h0008, "R6 both falling");
    reg_write(ST, 32'hFFFF);

    // R7 level on pad16, line 5
    reg_write(P16W0, 32'h5000_8200);
    reg_write(P16W1, 32'h4);
    pad_in[16] = 1'b1; tick(5);
    reg_write(ST, 32'h0020);
    reg_read(ST, 32'h0020, "R7 level reasserts");
    pad_in[16] = 1'b0; tick(5);
    reg_write(ST, 32'h0020);
    reg_read(ST, 0, "R7 level clears when idle");

    // R8 inversion
    reg_write(P16W1, 32'h44); tick(3);
    reg_write(ST, 32'h0020);
    reg_read(ST, 32'h0020, "R8 active-low level");
    pad_in[16] = 1'b1; tick(5);
    reg_write(ST, 32'h0020);
    reg_read(ST, 0, "R8 inverted high idle");

    // R9 suppressed detection
    reg_write(P16W0, 32'h5000_8300);
    reg_write(P16W1, 32'h4);
    tick(3); reg_write(ST, 32'hFFFF); tick(3);
    reg_read(ST, 0, "R9 rx disabled mode");
    reg_write(P16W1, 32'h0);
    reg_write(P16W0, 32'h5000_8200);
    pad_in[16] = 1'b0; tick(5);
    pad_in[16] = 1'b1; tick(5);
    reg_read(ST, 0, "R9 trigger none");
    reg_write(P16W0, 32'h5000_0200);
    reg_write(P16W1, 32'h2);
    pad_in[16] = 1'b0; tick(5);
    pad_in[16] = 1'b1; tick(5);
    reg_read(ST, 0, "R9 pad disabled");

    // R10 write-one-to-clear
    pad_in[0] = 1'b1; tick(5);
    reg_write(ST, 32'h0000);
    reg_read(ST, 32'h0008, "R10 zero keeps");
    reg_write(ST, 32'h0010);
    reg_read(ST, 32'h0008, "R10 other bit keeps");
    reg_write(ST, 32'h0008);
    reg_read(ST, 0, "R10 one clears");

    // R11 collision: edge set and clear on the same edge
    pad_in[0] = 1'b0;        // change before edge E0
    @(posedge clk); @(negedge clk);   // after E0: first stage
    @(posedge clk); @(negedge clk);   // after E1: event visible
    req_valid = 1'b1; req_write = 1'b1; req_addr = ST; req_wdata = 32'h0008;
    @(negedge clk);                   // E2 took both set and clear
    req_valid = 1'b0; req_write = 1'b0;
    reg_read(ST, 32'h0008, "R11 set wins");
    reg_write(ST, 32'h0008);
    reg_read(ST, 0, "R11 later clear works");

    // R12 mask and combined output
    reg_write(MK, 32'h0008);
    reg_read(MK, 32'h0008, "R12 mask readback");
    chk({31'b0, irq_out}, 0, "R12 irq idle");
    pad_in[0] = 1'b1; tick(5);
    chk({31'b0, irq_out}, 1, "R12 irq asserted");
    reg_write(MK, 32'h0004); tick(1);
    chk({31'b0, irq_out}, 0, "R12 irq masked");
    reg_write(MK, 32'h0008); tick(1);
    chk({31'b0, irq_out}, 1, "R12 irq unmasked");
    reg_write(ST, 32'h0008); tick(1);
    chk({31'b0, irq_out}, 0, "R12 irq after clear");

    tick(3);
    if (sb_q.size() != 0) begin
      compared++; mismatched++;
      $display("FAIL R2 missing responses actual=%0d expected=0", sb_q.size());
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule